// File: doc/BRIEF.md
# Prime-Count Banked Word Store

This block is a word-addressed memory split into a prime number of banks. Each bank holds a power-of-two number of words. A linear word address goes to a bank chosen by the address modulo the bank count. Inside that bank, the slot is chosen by the address modulo the bank depth. Because the two sizes share no common factor, every address below their product lands on its own (bank, slot) pair. Strides that are powers of two, such as walking down a column of a row-major array, therefore spread across all banks and do not pile onto one.

The modulo by the prime is a short chain of conditional subtractions, one per address bit, settled within a single cycle. No divider is used. The slot is just the low address bits. A request is sampled on a clock edge. Its response is registered and presented one cycle later. The response carries the chosen bank and slot, a range-error flag and, for reads, the stored word. By default there are 3 banks of 8 words, which covers addresses 0 to 23.

Top module: `prime_bank_mapper`

## Requirements
- R1: For every request, `bank_o` in the following cycle equals the request address modulo N_BANKS (default 3). For example, address 9 gives bank 0 and address 16 gives bank 1.
- R2: For every request, `offset_o` in the following cycle equals the request address modulo BANK_DEPTH (default 8), which is its low log2(BANK_DEPTH) bits. For example, address 9 gives offset 1 and address 16 gives offset 0.
- R3: A request whose address is at or above N_BANKS*BANK_DEPTH (default 24) raises `err_o` for one cycle in the following cycle, and writes nothing. In-range requests leave `err_o` low.
- R4: A read request (`req_i`=1, `we_i`=0) to an in-range address raises `rvalid_o` in the following cycle. In that same cycle `rdata_o` holds the last word written to that address, including a write made in the immediately preceding cycle.
- R5: The in-range addresses map to pairwise distinct (bank, offset) pairs.
- R6: While `rst_ni` is low, `rvalid_o`, `err_o` and `rdata_o` are all zero.
- R7: A write request (`we_i`=1) does not raise `rvalid_o` in the following cycle.
- R8: A read request to an out-of-range address raises both `rvalid_o` and `err_o`, with `rdata_o` zero.
- R9: A cycle with `req_i` low is followed by a cycle with `rvalid_o` and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Linear word address |
| wdata_i | input | DATA_W | Write word |
| rvalid_o | output | 1 | Read response valid |
| rdata_o | output | DATA_W | Read word |
| err_o | output | 1 | Address out of range |
| bank_o | output | BANK_W | Bank chosen for the last request |
| offset_o | output | OFF_W | Slot chosen for the last request |

## Verification
If the remainder chain is wrong, the fault shows in `bank_o` one cycle after the request. A wrong remainder also makes two addresses share a slot, so a full write-then-read sweep returns a stale word on the first read of the overwritten address. A broken range check either raises a false `err_o` on the next cycle, or lets an out-of-range write overwrite an in-range alias. That second fault surfaces on the next read of the alias (addresses 0, 3 and 7 for 24, 27 and 31). Any latency or read-enable fault shows as a misplaced `rvalid_o` one cycle after the request.

// File: rtl/prime_bank_pkg.sv
`timescale 1ns/1ps
package prime_bank_pkg;
  localparam int unsigned DEF_BANKS = 3;
  localparam int unsigned DEF_DEPTH = 8;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_ADDR_W = 5;
endpackage

// File: rtl/bank_mod_reduce.sv
`timescale 1ns/1ps
// Remainder by a small constant using one compare/subtract per address bit.
module bank_mod_reduce #(
  parameter int unsigned ADDR_W  = prime_bank_pkg::DEF_ADDR_W,
  parameter int unsigned N_BANKS = prime_bank_pkg::DEF_BANKS,
  localparam int unsigned BANK_W = $clog2(N_BANKS),
  localparam int unsigned W      = ADDR_W + BANK_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] rem_o
);
  logic [W-1:0] part [ADDR_W+1];

  assign part[0] = W'(addr_i);

  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_step
    localparam int unsigned SH = ADDR_W - 1 - gi;
    localparam logic [W-1:0] SUB = W'(N_BANKS) << SH;
    assign part[gi+1] = (part[gi] >= SUB) ? (part[gi] - SUB) : part[gi];
  end

  assign rem_o = part[ADDR_W][BANK_W-1:0];
endmodule

// File: rtl/addr_locate.sv
`timescale 1ns/1ps
module addr_locate #(
  parameter int unsigned ADDR_W     = prime_bank_pkg::DEF_ADDR_W,
  parameter int unsigned N_BANKS    = prime_bank_pkg::DEF_BANKS,
  parameter int unsigned BANK_DEPTH = prime_bank_pkg::DEF_DEPTH,
  localparam int unsigned BANK_W    = $clog2(N_BANKS),
  localparam int unsigned OFF_W     = $clog2(BANK_DEPTH)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              oor_o
);
  localparam logic [ADDR_W:0] CAP = (ADDR_W+1)'(N_BANKS * BANK_DEPTH);

  if (N_BANKS % 2 == 0) begin : g_bad_cfg
    $error("bank count must be odd to stay co-prime with a power-of-two depth");
  end

  bank_mod_reduce #(
    .ADDR_W (ADDR_W),
    .N_BANKS(N_BANKS)
  ) u_reduce (
    .addr_i(addr_i),
    .rem_o (bank_o)
  );

  // depth is a power of two: the modulo is the low bits
  assign offset_o = addr_i[OFF_W-1:0];
  assign oor_o    = {1'b0, addr_i} >= CAP;
endmodule

// File: rtl/bank_store.sv
`timescale 1ns/1ps
module bank_store #(
  parameter int unsigned N_BANKS    = prime_bank_pkg::DEF_BANKS,
  parameter int unsigned BANK_DEPTH = prime_bank_pkg::DEF_DEPTH,
  parameter int unsigned DATA_W     = prime_bank_pkg::DEF_DATA_W,
  localparam int unsigned BANK_W    = $clog2(N_BANKS),
  localparam int unsigned OFF_W     = $clog2(BANK_DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_bank [N_BANKS];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [BANK_DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (bank_i == BANK_W'(b))) mem[offset_i] <= wdata_i;
    end
    assign rd_bank[b] = mem[offset_i];
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (bank_i == BANK_W'(b)) rdata_o = rd_bank[b];
    end
  end
endmodule

// File: rtl/prime_bank_mapper.sv
`timescale 1ns/1ps
module prime_bank_mapper #(
  parameter int unsigned ADDR_W     = prime_bank_pkg::DEF_ADDR_W,
  parameter int unsigned N_BANKS    = prime_bank_pkg::DEF_BANKS,
  parameter int unsigned BANK_DEPTH = prime_bank_pkg::DEF_DEPTH,
  parameter int unsigned DATA_W     = prime_bank_pkg::DEF_DATA_W,
  localparam int unsigned BANK_W    = $clog2(N_BANKS),
  localparam int unsigned OFF_W     = $clog2(BANK_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFF_W-1:0]  offset_o
);
  logic [BANK_W-1:0] bank_d;
  logic [OFF_W-1:0]  off_d;
  logic              oor_d;
  logic [DATA_W-1:0] rd_d;
  logic              wr_en;

  addr_locate #(
    .ADDR_W    (ADDR_W),
    .N_BANKS   (N_BANKS),
    .BANK_DEPTH(BANK_DEPTH)
  ) u_locate (
    .addr_i  (addr_i),
    .bank_o  (bank_d),
    .offset_o(off_d),
    .oor_o   (oor_d)
  );

  assign wr_en = req_i && we_i && !oor_d;

  bank_store #(
    .N_BANKS   (N_BANKS),
    .BANK_DEPTH(BANK_DEPTH),
    .DATA_W    (DATA_W)
  ) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .bank_i  (bank_d),
    .offset_i(off_d),
    .wdata_i (wdata_i),
    .rdata_o (rd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
      rdata_o  <= '0;
      bank_o   <= '0;
      offset_o <= '0;
    end else begin
      rvalid_o <= req_i && !we_i;
      err_o    <= req_i && oor_d;
      if (req_i) begin
        bank_o   <= bank_d;
        offset_o <= off_d;
      end
      if (req_i && !we_i) rdata_o <= oor_d ? '0 : rd_d;
    end
  end
endmodule

// File: rtl/prime_bank_mapper_chk.sv
`timescale 1ns/1ps
module prime_bank_mapper_chk #(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned N_BANKS    = 3,
  parameter int unsigned BANK_DEPTH = 8,
  parameter int unsigned DATA_W     = 16,
  localparam int unsigned BANK_W    = $clog2(N_BANKS),
  localparam int unsigned OFF_W     = $clog2(BANK_DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [OFF_W-1:0]  offset_o
);
  localparam logic [ADDR_W:0] CAP = (ADDR_W+1)'(N_BANKS * BANK_DEPTH);

  a_r1_bank_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i) |-> (int'(bank_o) < N_BANKS));

  a_r2_offset_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (offset_o == $past(addr_i[OFF_W-1:0])));

  a_r3_err_when_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ({1'b0, addr_i} >= CAP)) |=> err_o);

  a_r3_no_err_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ({1'b0, addr_i} < CAP)) |=> !err_o);

  a_r4_read_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  a_r7_write_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> !rvalid_o);

  a_r8_err_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && err_o) |-> (rdata_o == '0));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rvalid_o && !err_o));
endmodule

bind prime_bank_mapper prime_bank_mapper_chk #(
  .ADDR_W    (ADDR_W),
  .N_BANKS   (N_BANKS),
  .BANK_DEPTH(BANK_DEPTH),
  .DATA_W    (DATA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rvalid_o(rvalid_o),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .bank_o  (bank_o),
  .offset_o(offset_o)
);

// File: tb/prime_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module prime_bank_mapper_tb_top;
  localparam int ADDR_W = 5, N_BANKS = 3, BANK_DEPTH = 8, DATA_W = 16;
  localparam int CAP = N_BANKS * BANK_DEPTH;

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic rvalid_o, err_o;
  logic [DATA_W-1:0] rdata_o;
  logic [1:0] bank_o;
  logic [2:0] offset_o;

  always #5 clk_i = ~clk_i;

  prime_bank_mapper #(
    .ADDR_W(ADDR_W), .N_BANKS(N_BANKS), .BANK_DEPTH(BANK_DEPTH), .DATA_W(DATA_W)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .err_o(err_o),
    .bank_o(bank_o), .offset_o(offset_o)
  );

  typedef struct {bit req; bit we; int addr; logic [DATA_W-1:0] data;} item_t;
  item_t q[$];
  logic [DATA_W-1:0] ref_mem [CAP];
  int owner [N_BANKS*BANK_DEPTH];
  int checks = 0, fails = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic drive(bit rq, bit wr, int a, logic [DATA_W-1:0] d);
    item_t it;
    @(negedge clk_i);
    req_i = rq; we_i = wr; addr_i = ADDR_W'(a); wdata_i = d;
    it.req = rq; it.we = wr; it.addr = a; it.data = d;
    q.push_back(it);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // scoreboard monitor: one item per clock edge
  always @(posedge clk_i) begin : mon
    item_t it;
    bit oor;
    int eb, eo, slot;
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      oor = it.addr >= CAP;
      eb = it.addr % N_BANKS;
      eo = it.addr % BANK_DEPTH;
      if (!it.req) begin
        check("R9 rvalid", 32'(rvalid_o), 0);
        check("R9 err", 32'(err_o), 0);
      end else begin
        check(it.we ? "R7 rvalid" : "R4 rvalid", 32'(rvalid_o), it.we ? 0 : 1);
        check("R3 err", 32'(err_o), 32'(oor));
        check("R1 bank", 32'(bank_o), 32'(eb));
        check("R2 offset", 32'(offset_o), 32'(eo));
        if (!it.we) begin
          if (oor) check("R8 rdata", 32'(rdata_o), 0);
          else     check("R4 rdata", 32'(rdata_o), 32'(ref_mem[it.addr]));
        end
        if (!oor) begin
          slot = eb * BANK_DEPTH + eo;
          checks++;
          if (owner[slot] == -1) owner[slot] = it.addr;
          else if (owner[slot] != it.addr) begin
            fails++;
            $display("FAIL R5 slot %0d: actual addr %0d expected owner %0d",
                     slot, it.addr, owner[slot]);
          end
          if (it.we) ref_mem[it.addr] = it.data;
        end
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N_BANKS*BANK_DEPTH; i++) owner[i] = -1;
    for (int i = 0; i < CAP; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk_i);
    check("R6 rvalid", 32'(rvalid_o), 0);
    check("R6 err", 32'(err_o), 0);
    check("R6 rdata", 32'(rdata_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // fill every in-range address with a distinct word, then read all back
    for (int a = 0; a < CAP; a++) drive(1, 1, a, 16'hA500 ^ 16'(a * 37));
    for (int a = 0; a < CAP; a++) drive(1, 0, a, '0);
    drive(0, 0, 0, '0);
    drive(0, 0, 0, '0);

    // R1/R2 example points: 9 -> (0,1), 16 -> (1,0)
    drive(1, 0, 9, '0);
    drive(1, 0, 16, '0);

    // power-of-two stride 8 lands in three different banks
    drive(1, 1, 0, 16'h1111);
    drive(1, 1, 8, 16'h2222);
    drive(1, 1, 16, 16'h3333);
    drive(1, 0, 16, '0);
    drive(1, 0, 8, '0);
    drive(1, 0, 0, '0);

    // R3: out-of-range writes must not touch their aliases 0, 3, 7
    drive(1, 1, 24, 16'hDEAD);
    drive(1, 1, 27, 16'hBEEF);
    drive(1, 1, 31, 16'hCAFE);
    drive(1, 0, 0, '0);
    drive(1, 0, 3, '0);
    drive(1, 0, 7, '0);
    // R8: out-of-range reads
    drive(1, 0, 30, '0);
    drive(1, 0, 24, '0);

    // R4: read directly after write to the same address
    drive(1, 1, 13, 16'h5A5A);
    drive(1, 0, 13, '0);
    drive(1, 1, 23, 16'h0F0F);
    drive(1, 0, 23, '0);
    drive(0, 0, 0, '0);
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule